// File: doc/BRIEF.md
# Snooping Pixel Fetch Engine

This block sits between a small 8-bit processor, the processor's video output register and a 512 KB static RAM. Each processor cycle is split into four access slots on a clock that runs four times faster. Slot 0 always belongs to the processor's own read or write. The remaining slots fetch pixels, so the processor and the video path share the RAM without delaying each other.

The processor still sets all video timing. To start a scanline it issues one output instruction whose operand comes from a memory page other than page zero. From then on the block fetches the following bytes of that page by itself and drives them to the video output on every processor cycle. Meanwhile the processor runs ordinary code. The run stops at the next output instruction that is not a pixel: one whose value reads no memory, or reads page zero. That value, and any other value output outside a run, goes straight to the output register.

The frame buffer may sit in a bank other than the processor's current 64 KB window. A double-width mode fetches and shows two pixels per processor cycle.

Top module: `pixel_snoop_engine`

## Requirements
- R1: In reset and afterwards, while no run is active, `vid_out` is 0x00, `ram_we` is low, no pixel fetch happens, slots 1 to 3 present the processor address, and the video bank is 0.
- R2: In slot 0 (the first fast clock of each processor cycle) `ram_addr` equals `{cpu_bank, cpu_addr}`, `ram_we` equals `cpu_we` and `ram_wdata` equals `cpu_wdata`.
- R3: From slot 1 to slot 3 of a processor cycle, `cpu_rdata` holds the RAM byte read at the processor address in slot 0 of that cycle.
- R4: An output with `cpu_out_en=1`, `cpu_out_mem=1` and `cpu_addr[15:8]` nonzero starts a run. In slot 1 of that cycle `ram_addr` is `{video bank, cpu_addr}`, and the fetched byte appears on `vid_out` from slot 0 of the next cycle.
- R5: In each later cycle with `cpu_out_en=0`, a run fetches the next address. Only the low byte advances; it wraps from 0xFF to 0x00 and the page stays the same.
- R6: An output with `cpu_out_mem=0`, or with `cpu_addr[15:8]` zero, ends the run. No fetch happens in that cycle, and `vid_out` shows `cpu_out_val` from the next cycle on.
- R7: `vid_out` changes only at the end of slot 3, or at the end of slot 1 in double-width mode. With no run and no output instruction it holds its value.
- R8: With `hires=1`, a fetching cycle reads the low bytes L (slot 1) and L+1 (slot 2). The next cycle shows pixel L in slots 0 and 1 and pixel L+1 in slots 2 and 3, and the run then advances by two.
- R9: A cycle with `vbank_wr=1` loads `vbank_val` as the video bank, which pixel fetches use from the next cycle on. Slot 0 keeps using `cpu_bank`.
- R10: A starting output during an active run reloads the run address from the new `cpu_addr`.
- R11: `ram_we` is never high outside slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four slots per processor cycle, phase aligned |
| rst_n | input | 1 | Synchronous active-low reset, released aligned to a processor cycle |
| cpu_addr | input | 16 | Processor memory address, held for the whole processor cycle |
| cpu_bank | input | 3 | Processor's current bank |
| cpu_we | input | 1 | Processor write in this cycle |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Byte read for the processor in slot 0 |
| cpu_out_en | input | 1 | Output instruction in this cycle |
| cpu_out_mem | input | 1 | Output operand is read from memory |
| cpu_out_val | input | 8 | Value the processor outputs |
| hires | input | 1 | Double-width pixel mode |
| vbank_wr | input | 1 | Load a new video bank at the end of this cycle |
| vbank_val | input | 3 | New video bank |
| ram_addr | output | 19 | RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid within the slot |
| vid_out | output | 8 | Video output register |

## Verification
A slot counter that has lost its phase shows at once: in the very next processor cycle the processor address or the write strobe appears in the wrong slot on the RAM port. A wrong run flag or run address shows up within one processor cycle, as a pixel fetch address on `ram_addr` in slot 1 that does not match. It then shows one cycle later as a wrong byte on `vid_out`. Because the reference model is compared on every fast clock, a stale double-width pending flag is caught in the slot where `vid_out` should or should not have moved.

// File: rtl/pxs_pkg.sv
// Shared types for the snooping pixel fetch engine.
// Assumes four fast-clock slots per processor cycle.
package pxs_pkg;
    // Fixed access slot order inside one processor cycle
    typedef enum logic [1:0] {
        SLOT_CPU  = 2'd0,
        SLOT_PIXA = 2'd1,
        SLOT_PIXB = 2'd2,
        SLOT_IDLE = 2'd3
    } slot_t;

    // What the current processor cycle does to the pixel run
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_START = 2'd1,
        ACT_CONT  = 2'd2,
        ACT_STOP  = 2'd3
    } run_act_t;
endpackage

// File: rtl/pxs_slot_seq.sv
// Slot sequencer: counts the four fast-clock slots of a processor cycle.
// Assumes reset is released on a processor-cycle boundary.
module pxs_slot_seq
    import pxs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_t slot
);
    logic [1:0] cnt_q;

    // Advance the slot index every fast clock, wrapping after slot 3
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= 2'd0;
        else        cnt_q <= cnt_q + 2'd1;
    end

    assign slot = slot_t'(cnt_q);
endmodule

// File: rtl/pxs_run_ctrl.sv
// Run controller: decodes snooped output instructions, keeps the run flag,
// the in-page pixel address and the video bank register.
// Assumes processor inputs are stable for all four slots of a cycle.
module pxs_run_ctrl
    import pxs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t             slot,
    input  logic              cpu_out_en,
    input  logic              cpu_out_mem,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              hires,
    input  logic              vbank_wr,
    input  logic [BANK_W-1:0] vbank_val,
    output run_act_t          act,
    output logic              active,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] fetch_base,
    output logic [BANK_W-1:0] vbank
);
    logic              page_nz;
    logic              is_start;
    logic [PAGE_W-1:0] step;
    logic [PAGE_W-1:0] next_lo;

    assign page_nz  = |cpu_addr[ADDR_W-1:PAGE_W];
    assign is_start = cpu_out_en && cpu_out_mem && page_nz;

    // Classify this processor cycle's effect on the run
    always_comb begin
        if (is_start)        act = ACT_START;
        else if (cpu_out_en) act = ACT_STOP;
        else if (active)     act = ACT_CONT;
        else                 act = ACT_NONE;
    end

    assign fetch_base = is_start ? cpu_addr : ptr;
    assign step       = hires ? PAGE_W'(2) : PAGE_W'(1);
    assign next_lo    = fetch_base[PAGE_W-1:0] + step;

    // Update run flag and pixel address at the end of the processor cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ptr    <= '0;
        end else if (slot == SLOT_IDLE) begin
            case (act)
                ACT_START, ACT_CONT: begin
                    active <= 1'b1;
                    ptr    <= {fetch_base[ADDR_W-1:PAGE_W], next_lo};
                end
                ACT_STOP: active <= 1'b0;
                default:  active <= active;
            endcase
        end
    end

    // Load the video bank at the end of the processor cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                           vbank <= '0;
        else if (slot == SLOT_IDLE && vbank_wr) vbank <= vbank_val;
    end
endmodule

// File: rtl/pxs_ram_port.sv
// RAM port: multiplexes the processor slot and the pixel lanes onto the
// single RAM bus, and captures the bytes read in each slot.
// Assumes RAM read data is valid before the end of each fast-clock slot.
module pxs_ram_port
    import pxs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  slot_t                    slot,
    input  logic [BANK_W-1:0]        cpu_bank,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_we,
    input  logic [DATA_W-1:0]        cpu_wdata,
    input  logic                     fetch_en,
    input  logic                     hires,
    input  logic [BANK_W-1:0]        vbank,
    input  logic [ADDR_W-1:0]        fetch_base,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic [BANK_W+ADDR_W-1:0] ram_addr,
    output logic                     ram_we,
    output logic [DATA_W-1:0]        ram_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic [DATA_W-1:0]        pix_a,
    output logic [DATA_W-1:0]        pix_b
);
    localparam int RAM_W = BANK_W + ADDR_W;

    logic [RAM_W-1:0]  lane_addr [LANES];
    logic              lane_on   [LANES];
    logic [DATA_W-1:0] lane_q    [LANES];

    // One pixel lane per slot after the processor slot
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_addr[i] = {vbank, fetch_base[ADDR_W-1:PAGE_W],
                               fetch_base[PAGE_W-1:0] + PAGE_W'(i)};
        assign lane_on[i]   = fetch_en && (slot == slot_t'(2'(i + 1)))
                              && ((i == 0) || hires);

        // Capture the pixel byte read in this lane's slot
        always_ff @(posedge clk) begin
            if (!rst_n)          lane_q[i] <= '0;
            else if (lane_on[i]) lane_q[i] <= ram_rdata;
        end
    end

    // Choose the address driving the RAM in the current slot
    always_comb begin
        ram_addr = {cpu_bank, cpu_addr};
        for (int k = 0; k < LANES; k++) begin
            if (lane_on[k]) ram_addr = lane_addr[k];
        end
    end

    assign ram_we    = (slot == SLOT_CPU) && cpu_we;
    assign ram_wdata = cpu_wdata;

    // Hold the processor's read byte from the end of its slot
    always_ff @(posedge clk) begin
        if (!rst_n)                cpu_rdata <= '0;
        else if (slot == SLOT_CPU) cpu_rdata <= ram_rdata;
    end

    assign pix_a = lane_q[0];
    assign pix_b = lane_q[1];
endmodule

// File: rtl/pxs_video_out.sv
// Video output register: shows fetched pixels during a run, passes other
// output values through, and swaps in the second pixel in double width.
// Assumes pixel bytes are captured by the RAM port before slot 3 ends.
module pxs_video_out
    import pxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t             slot,
    input  run_act_t          act,
    input  logic              hires,
    input  logic [DATA_W-1:0] cpu_out_val,
    input  logic [DATA_W-1:0] pix_a,
    input  logic [DATA_W-1:0] pix_b,
    output logic [DATA_W-1:0] vid_out
);
    logic pend_b;

    // Load the output at cycle end, or the second pixel at mid cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_out <= '0;
            pend_b  <= 1'b0;
        end else if (slot == SLOT_IDLE) begin
            case (act)
                ACT_START, ACT_CONT: begin
                    vid_out <= pix_a;
                    pend_b  <= hires;
                end
                ACT_STOP: begin
                    vid_out <= cpu_out_val;
                    pend_b  <= 1'b0;
                end
                default: pend_b <= 1'b0;
            endcase
        end else if (slot == SLOT_PIXA && pend_b) begin
            vid_out <= pix_b;
            pend_b  <= 1'b0;
        end
    end
endmodule

// File: rtl/pixel_snoop_engine.sv
// Top of the snooping pixel fetch engine: slot sequencer, run controller,
// RAM port and video output register.
// Assumes clk runs at four times the processor clock and is phase aligned.
module pixel_snoop_engine
    import pxs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [BANK_W-1:0]        cpu_bank,
    input  logic                     cpu_we,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    input  logic                     cpu_out_en,
    input  logic                     cpu_out_mem,
    input  logic [DATA_W-1:0]        cpu_out_val,
    input  logic                     hires,
    input  logic                     vbank_wr,
    input  logic [BANK_W-1:0]        vbank_val,
    output logic [BANK_W+ADDR_W-1:0] ram_addr,
    output logic                     ram_we,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic [DATA_W-1:0]        vid_out
);
    slot_t             slot_w;
    run_act_t          act_w;
    logic              run_active;
    logic [ADDR_W-1:0] run_ptr;
    logic [ADDR_W-1:0] fetch_base;
    logic [BANK_W-1:0] vbank;
    logic              fetch_en;
    logic [DATA_W-1:0] pix_a;
    logic [DATA_W-1:0] pix_b;

    assign fetch_en = (act_w == ACT_START) || (act_w == ACT_CONT);

    pxs_slot_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot_w)
    );

    pxs_run_ctrl #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W)) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot        (slot_w),
        .cpu_out_en  (cpu_out_en),
        .cpu_out_mem (cpu_out_mem),
        .cpu_addr    (cpu_addr),
        .hires       (hires),
        .vbank_wr    (vbank_wr),
        .vbank_val   (vbank_val),
        .act         (act_w),
        .active      (run_active),
        .ptr         (run_ptr),
        .fetch_base  (fetch_base),
        .vbank       (vbank)
    );

    pxs_ram_port #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
                   .PAGE_W(PAGE_W)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot_w),
        .cpu_bank   (cpu_bank),
        .cpu_addr   (cpu_addr),
        .cpu_we     (cpu_we),
        .cpu_wdata  (cpu_wdata),
        .fetch_en   (fetch_en),
        .hires      (hires),
        .vbank      (vbank),
        .fetch_base (fetch_base),
        .ram_rdata  (ram_rdata),
        .ram_addr   (ram_addr),
        .ram_we     (ram_we),
        .ram_wdata  (ram_wdata),
        .cpu_rdata  (cpu_rdata),
        .pix_a      (pix_a),
        .pix_b      (pix_b)
    );

    pxs_video_out #(.DATA_W(DATA_W)) u_vid (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot        (slot_w),
        .act         (act_w),
        .hires       (hires),
        .cpu_out_val (cpu_out_val),
        .pix_a       (pix_a),
        .pix_b       (pix_b),
        .vid_out     (vid_out)
    );
endmodule

// File: rtl/pxs_checker.sv
// Property checker for the snooping pixel fetch engine, bound to the top.
// Assumes the slot index and run state are brought out of the top.
module pxs_checker #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int PAGE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               slot,
    input logic                     active,
    input logic [ADDR_W-1:0]        ptr,
    input logic                     ram_we,
    input logic [BANK_W+ADDR_W-1:0] ram_addr,
    input logic [ADDR_W-1:0]        cpu_addr,
    input logic [BANK_W-1:0]        cpu_bank,
    input logic                     cpu_out_en,
    input logic                     cpu_out_mem,
    input logic [7:0]               vid_out
);
    logic pixel_out;
    assign pixel_out = cpu_out_en && cpu_out_mem && (|cpu_addr[ADDR_W-1:PAGE_W]);

    // R11
    we_only_cpu_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (slot == 2'd0));

    // R2
    cpu_slot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 2'd0) |-> (ram_addr == {cpu_bank, cpu_addr}));

    // R7
    vid_change_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vid_out) |-> ($past(slot) == 2'd3 || $past(slot) == 2'd1));

    // R4
    start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 2'd3 && pixel_out) |=> active);

    // R6
    stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 2'd3 && cpu_out_en && !pixel_out) |=> !active);

    // R5
    page_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 2'd3 && active && !cpu_out_en)
        |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

    // R1
    idle_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cpu_out_en) |-> (ram_addr == {cpu_bank, cpu_addr}));
endmodule

bind pixel_snoop_engine pxs_checker #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot        (slot_w),
    .active      (run_active),
    .ptr         (run_ptr),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .cpu_addr    (cpu_addr),
    .cpu_bank    (cpu_bank),
    .cpu_out_en  (cpu_out_en),
    .cpu_out_mem (cpu_out_mem),
    .vid_out     (vid_out)
);

// File: tb/pixel_snoop_engine_tb.sv
// Bench: behavioural per-cycle reference model compared on every fast clock.
module pixel_snoop_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [2:0]  cpu_bank = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_out_en = 1'b0;
    logic        cpu_out_mem = 1'b0;
    logic [7:0]  cpu_out_val = '0;
    logic        hires = 1'b0;
    logic        vbank_wr = 1'b0;
    logic [2:0]  vbank_val = '0;
    logic [18:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;
    logic [7:0]  vid_out;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    bit          m_active = 0;
    logic [15:0] m_ptr = '0;
    logic [2:0]  m_vb = '0;
    logic [7:0]  m_vid = '0;
    bit          m_pend = 0;
    logic [7:0]  m_b = '0;

    always #2 clk = ~clk;

    // RAM contents as a pure function of the address
    function automatic logic [7:0] memf(input logic [18:0] a);
        logic [7:0] hi;
        hi = a[15:8];
        return a[7:0] ^ 8'(hi * 8'd29) ^ {a[18:16], 5'b0};
    endfunction

    assign ram_rdata = memf(ram_addr);

    pixel_snoop_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_bank(cpu_bank),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_out_en(cpu_out_en), .cpu_out_mem(cpu_out_mem),
        .cpu_out_val(cpu_out_val), .hires(hires), .vbank_wr(vbank_wr),
        .vbank_val(vbank_val), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .vid_out(vid_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One processor cycle: drive inputs, check all four slots, step the model
    task automatic cyc(input string tag, input bit oe, input bit om,
                       input logic [15:0] a, input logic [2:0] bk,
                       input bit we, input logic [7:0] wd, input logic [7:0] ov,
                       input bit hr, input bit vw, input logic [2:0] vv);
        bit          start;
        bit          fetch;
        logic [15:0] base;
        logic [18:0] la, lb;
        cpu_out_en = oe; cpu_out_mem = om; cpu_addr = a; cpu_bank = bk;
        cpu_we = we; cpu_wdata = wd; cpu_out_val = ov; hires = hr;
        vbank_wr = vw; vbank_val = vv;
        start = oe && om && (a[15:8] != 8'h00);
        fetch = start || (!oe && m_active);
        base  = start ? a : m_ptr;
        la = {m_vb, base};
        lb = {m_vb, base[15:8], 8'(base[7:0] + 8'd1)};
        for (int s = 0; s < 4; s++) begin
            #1;
            check(vid_out === m_vid, tag, vid_out, m_vid);
            if (s == 0) begin
                check(ram_addr === {bk, a}, "R2", ram_addr, {bk, a});
                check(ram_we === we, "R2", ram_we, we);
                if (we) check(ram_wdata === wd, "R2", ram_wdata, wd);
            end else begin
                check(ram_we === 1'b0, "R11", ram_we, 0);
                if (!we) check(cpu_rdata === memf({bk, a}), "R3", cpu_rdata, memf({bk, a}));
            end
            if (s == 1) begin
                if (fetch) check(ram_addr === la, tag, ram_addr, la);
                else       check(ram_addr === {bk, a}, "R1", ram_addr, {bk, a});
            end
            if (s == 2 && fetch && hr) check(ram_addr === lb, "R8", ram_addr, lb);
            @(posedge clk);
            if (s == 1 && m_pend) begin
                m_vid = m_b; m_pend = 0;
            end
            if (s == 3) begin
                if (fetch) begin
                    m_vid = memf(la); m_b = memf(lb); m_pend = hr;
                    m_ptr = {base[15:8], 8'(base[7:0] + (hr ? 8'd2 : 8'd1))};
                    m_active = 1;
                end else if (oe) begin
                    m_vid = ov; m_active = 0; m_pend = 0;
                end else begin
                    m_pend = 0;
                end
                if (vw) m_vb = vv;
            end
            @(negedge clk);
        end
    endtask

    // A run-continuing cycle with varied processor traffic
    task automatic cont(input string tag, input int k, input bit hr);
        cyc(tag, 0, 0, 16'h9000 + 16'(k * 7), 3'd1, (k % 3) == 0, 8'(k * 13), 8'h00, hr, 0, 3'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(vid_out === 8'h00, "R1", vid_out, 0);
        check(ram_we === 1'b0, "R1", ram_we, 0);
        rst_n = 1'b1;

        // R1 / R7: idle, output holds
        for (int k = 0; k < 2; k++) cyc("R1", 0, 0, 16'h1234 + 16'(k), 3'd2, 0, 8'h00, 8'h00, 0, 0, 3'd0);
        // R7: pass-through outside a run, then hold
        cyc("R7", 1, 0, 16'h0000, 3'd0, 0, 8'h00, 8'hC0, 0, 0, 3'd0);
        cyc("R7", 0, 0, 16'h0001, 3'd0, 0, 8'h00, 8'h11, 0, 0, 3'd0);
        cyc("R7", 0, 0, 16'h0002, 3'd0, 0, 8'h00, 8'h22, 0, 0, 3'd0);

        // R4 / R5: start and continue a normal-width run
        cyc("R4", 1, 1, 16'h1220, 3'd1, 0, 8'h00, 8'h00, 0, 0, 3'd0);
        for (int k = 0; k < 5; k++) cont("R5", k, 0);
        // R6: end with a non-memory output
        cyc("R6", 1, 0, 16'h5555, 3'd1, 0, 8'h00, 8'h3F, 0, 0, 3'd0);
        cyc("R7", 0, 0, 16'h5556, 3'd1, 1, 8'h77, 8'h00, 0, 0, 3'd0);
        cyc("R7", 0, 0, 16'h5557, 3'd1, 0, 8'h00, 8'h00, 0, 0, 3'd0);

        // R5: wrap within the page
        cyc("R4", 1, 1, 16'h34FE, 3'd0, 0, 8'h00, 8'h00, 0, 0, 3'd0);
        for (int k = 0; k < 4; k++) cont("R5", k + 10, 0);
        // R6: end with a page-zero memory output
        cyc("R6", 1, 1, 16'h0050, 3'd0, 0, 8'h00, 8'h00, 0, 0, 3'd0);
        cyc("R6", 0, 0, 16'h0051, 3'd0, 0, 8'h00, 8'h00, 0, 0, 3'd0);

        // R9: set the video bank, then a double-width run (R8)
        cyc("R9", 0, 0, 16'h2000, 3'd1, 0, 8'h00, 8'h00, 0, 1, 3'd5);
        cyc("R9", 1, 1, 16'h4410, 3'd1, 0, 8'h00, 8'h00, 1, 0, 3'd0);
        for (int k = 0; k < 3; k++) cont("R8", k + 20, 1);
        cyc("R8", 1, 0, 16'h0000, 3'd1, 0, 8'h00, 8'h81, 0, 0, 3'd0);
        cyc("R8", 0, 0, 16'h0000, 3'd1, 0, 8'h00, 8'h00, 0, 0, 3'd0);
        // R8: double-width wrap within the page
        cyc("R8", 1, 1, 16'h6BFD, 3'd2, 0, 8'h00, 8'h00, 1, 0, 3'd0);
        for (int k = 0; k < 3; k++) cont("R8", k + 30, 1);

        // R10: restart during a run, with the bank back to 0
        cyc("R9", 0, 0, 16'h0100, 3'd0, 0, 8'h00, 8'h00, 0, 1, 3'd0);
        cyc("R10", 1, 1, 16'h2000, 3'd3, 0, 8'h00, 8'h00, 0, 0, 3'd0);
        for (int k = 0; k < 2; k++) cont("R10", k + 40, 0);
        cyc("R10", 1, 1, 16'h3080, 3'd3, 1, 8'hA5, 8'h00, 0, 0, 3'd0);
        for (int k = 0; k < 3; k++) cont("R10", k + 50, 0);
        cyc("R6", 1, 0, 16'h0000, 3'd0, 0, 8'h00, 8'h5A, 0, 0, 3'd0);
        cyc("R7", 0, 0, 16'h0003, 3'd0, 0, 8'h00, 8'h00, 0, 0, 3'd0);

        summary();
    end
endmodule